// File: doc/BRIEF.md
# Single-Master Address Decoder with Byte-Lane Width Adaptation

This block connects one bus master to several slave ports, each with its own power-of-two address window and a data width of 8 bits or more, up to the master's width. It is fully combinational. A master cycle whose byte address falls inside a window selects that slave. Cycle and strobe reach only the selected slave. Write enable and the offset within the window go to every slave. The selected slave's acknowledge and read data come back to the master.

A slave narrower than the master sees one lane group of the master's data bus. The master's byte lanes are cut into groups as wide as the slave, and the low address bits name the active group. Write bytes and byte selects are taken from that group. Read bytes are placed back on the lanes of that group, and every other lane reads as zero. Each master byte lane has its own read multiplexer.

The slave count, widths, base addresses and window sizes are elaboration parameters. With one slave, the select vector is a single bit.

Top module: `busdec_wa`

## Requirements
- R1: A slave is selected when `m_cyc` is 1 and `m_adr` lies in [base, base + 2^span). `o_cyc[s]` equals `m_cyc` AND selected. At most one slave is selected at a time.
- R2: `o_stb[s]` is `m_stb` AND the slave's select. `o_we[s]` is `m_we` for every slave. `o_adr` slice s (AW bits at s*AW) is `m_adr` modulo 2^span of slave s, for every slave.
- R3: `m_ack` equals `i_ack[s]` of the selected slave. It is 0 when no slave is selected, whatever the `i_ack` inputs are.
- R4: For a slave of WB bytes, the active lane group is g = (m_adr mod MB) / WB, where MB = MDW/8 is the master byte-select count. A full-width slave always uses group 0. The slave byte select is `m_sel` bits [g*WB +: WB], packed per slave in index order in `o_sel`.
- R5: A slave's write data is `m_wdat` bits [g*WB*8 +: WB*8] for its active group g. Slave data slices are packed in index order in `o_wdat` and `i_rdat`.
- R6: For a selected slave, master byte lanes g*WB to g*WB+WB-1 carry the slave's read bytes in order. All other lanes read zero, and `m_sel` has no effect on read data.
- R7: When no slave is selected (unmapped address or `m_cyc` = 0), `m_rdat` is all zero, `m_ack` is 0, and every `o_cyc` and `o_stb` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_cyc | input | 1 | Master cycle valid |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | AW | Master byte address |
| m_sel | input | MDW/8 | Master byte selects |
| m_wdat | input | MDW | Master write data |
| m_rdat | output | MDW | Read data to master |
| m_ack | output | 1 | Acknowledge to master |
| o_cyc | output | NS | Per-slave cycle |
| o_stb | output | NS | Per-slave strobe |
| o_we | output | NS | Per-slave write enable |
| o_adr | output | NS*AW | Per-slave window offset |
| o_sel | output | sum of widths/8 | Per-slave byte selects, packed |
| o_wdat | output | sum of widths | Per-slave write data, packed |
| i_rdat | input | sum of widths | Per-slave read data, packed |
| i_ack | input | NS | Per-slave acknowledge |

## Verification
Some properties are checked by assertions on every evaluation:
- at most one slave is selected, and none without a cycle;
- exactly one lane group is active for each width;
- no strobe reaches a slave without a master strobe;
- an unselected access returns zero data and no acknowledge.

Other properties need the bench's reference model, which compares every port on every clock:
- the exact window edges;
- which bytes of the write data and byte selects reach a narrow slave;
- the lane placement of narrow read data;
- that acknowledges from unselected slaves are ignored.

// File: rtl/busdec_pkg.sv
package busdec_pkg;
  function automatic int unsigned lg2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/busdec_addr.sv
module busdec_addr #(
  parameter int unsigned AW = 16,
  parameter int unsigned NS = 3,
  parameter int unsigned BASE [NS] = '{32'h0000, 32'h0100, 32'h1000},
  parameter int unsigned SPAN [NS] = '{8, 8, 12}
) (
  input  logic             cyc,
  input  logic [AW-1:0]    adr,
  output logic [NS-1:0]    hit,
  output logic [NS*AW-1:0] off
);
  for (genvar s = 0; s < NS; s++) begin : g_win
    localparam int unsigned SP = SPAN[s];
    localparam logic [AW-1:0] MASK = AW'((64'd1 << SP) - 64'd1);
    localparam logic [AW-1:0] TAG  = AW'(BASE[s] >> SP);
    assign hit[s] = cyc && ((adr >> SP) == TAG);
    assign off[s*AW +: AW] = adr & MASK;
  end

  always_comb begin
    p_onehot_sel_r1: assert ($onehot0(hit));
    if (!cyc) begin
      p_idle_nosel_r7: assert (hit == '0);
    end
  end
endmodule

// File: rtl/busdec_groups.sv
module busdec_groups
  import busdec_pkg::*;
#(
  parameter int unsigned MB = 4,
  parameter int unsigned AW = 16,
  localparam int unsigned LMB = lg2(MB)
) (
  input  logic [AW-1:0]             adr,
  output logic [LMB:0][MB-1:0]      grp
);
  int unsigned lo;
  always_comb begin
    lo  = 32'(adr) & (MB - 1);
    grp = '0;
    for (int w = 0; w <= int'(LMB); w++) begin
      grp[w][lo >> w] = 1'b1;
    end
  end

  always_comb begin
    for (int w = 0; w <= int'(LMB); w++) begin
      p_one_group_r4: assert ($countones(grp[w]) == 1);
    end
  end
endmodule

// File: rtl/busdec_wsteer.sv
module busdec_wsteer #(
  parameter int unsigned MB = 4,
  parameter int unsigned WB = 2,
  localparam int unsigned NG = MB / WB
) (
  input  logic [NG-1:0]   grow,
  input  logic [MB-1:0]   m_sel,
  input  logic [MB*8-1:0] m_wdat,
  output logic [WB-1:0]   s_sel,
  output logic [WB*8-1:0] s_wdat
);
  always_comb begin
    s_sel  = '0;
    s_wdat = '0;
    for (int g = 0; g < int'(NG); g++) begin
      if (grow[g]) begin
        s_sel  = s_sel  | m_sel[g*WB +: WB];
        s_wdat = s_wdat | m_wdat[g*WB*8 +: WB*8];
      end
    end
  end

  always_comb begin
    p_group_onehot_r5: assert ($countones(grow) == 1);
  end
endmodule

// File: rtl/busdec_rmerge.sv
module busdec_rmerge
  import busdec_pkg::*;
#(
  parameter int unsigned MB = 4,
  parameter int unsigned NS = 3,
  parameter int unsigned SLV_W [NS] = '{8, 16, 32},
  localparam int unsigned LMB = lg2(MB)
) (
  input  logic [NS-1:0]        hit,
  input  logic [LMB:0][MB-1:0] grp,
  input  logic [tot_w()-1:0]   i_rdat,
  input  logic [NS-1:0]        i_ack,
  output logic [MB*8-1:0]      m_rdat,
  output logic                 m_ack
);
  function automatic int unsigned tot_w();
    int unsigned t;
    t = 0;
    for (int i = 0; i < int'(NS); i++) t += SLV_W[i];
    return t;
  endfunction

  function automatic int unsigned woff(input int s);
    int unsigned t;
    t = 0;
    for (int i = 0; i < s; i++) t += SLV_W[i];
    return t;
  endfunction

  // Priority chains: the lowest slave index is evaluated last and wins.
  always_comb begin
    m_ack = 1'b0;
    for (int s = int'(NS) - 1; s >= 0; s--) begin
      if (hit[s]) m_ack = i_ack[s];
    end
  end

  always_comb begin
    m_rdat = '0;
    for (int l = 0; l < int'(MB); l++) begin
      for (int s = int'(NS) - 1; s >= 0; s--) begin
        int unsigned wb, lw;
        wb = SLV_W[s] / 8;
        lw = lg2(wb);
        if (hit[s] && grp[lw][l >> lw])
          m_rdat[l*8 +: 8] = i_rdat[woff(s) + (32'(l) % wb) * 8 +: 8];
      end
    end
  end

  always_comb begin
    if (hit == '0) begin
      p_quiet_unmapped_r7: assert (!m_ack && m_rdat == '0);
    end
  end
endmodule

// File: rtl/busdec_wa.sv
module busdec_wa
  import busdec_pkg::*;
#(
  parameter int unsigned MDW = 32,
  parameter int unsigned AW  = 16,
  parameter int unsigned NS  = 3,
  parameter int unsigned SLV_W    [NS] = '{8, 16, 32},
  parameter int unsigned SLV_BASE [NS] = '{32'h0000, 32'h0100, 32'h1000},
  parameter int unsigned SLV_SPAN [NS] = '{8, 8, 12},
  localparam int unsigned MB  = MDW / 8,
  localparam int unsigned LMB = lg2(MB)
) (
  input  logic                   m_cyc,
  input  logic                   m_stb,
  input  logic                   m_we,
  input  logic [AW-1:0]          m_adr,
  input  logic [MB-1:0]          m_sel,
  input  logic [MDW-1:0]         m_wdat,
  output logic [MDW-1:0]         m_rdat,
  output logic                   m_ack,
  output logic [NS-1:0]          o_cyc,
  output logic [NS-1:0]          o_stb,
  output logic [NS-1:0]          o_we,
  output logic [NS*AW-1:0]       o_adr,
  output logic [tot_w()/8-1:0]   o_sel,
  output logic [tot_w()-1:0]     o_wdat,
  input  logic [tot_w()-1:0]     i_rdat,
  input  logic [NS-1:0]          i_ack
);
  function automatic int unsigned tot_w();
    int unsigned t;
    t = 0;
    for (int i = 0; i < int'(NS); i++) t += SLV_W[i];
    return t;
  endfunction

  function automatic int unsigned woff(input int s);
    int unsigned t;
    t = 0;
    for (int i = 0; i < s; i++) t += SLV_W[i];
    return t;
  endfunction

  logic [NS-1:0]        hit;
  logic [LMB:0][MB-1:0] grp;

  busdec_addr #(.AW(AW), .NS(NS), .BASE(SLV_BASE), .SPAN(SLV_SPAN)) u_addr (
    .cyc(m_cyc), .adr(m_adr), .hit(hit), .off(o_adr)
  );

  busdec_groups #(.MB(MB), .AW(AW)) u_grp (.adr(m_adr), .grp(grp));

  for (genvar s = 0; s < NS; s++) begin : g_slv
    localparam int unsigned WB  = SLV_W[s] / 8;
    localparam int unsigned LW  = lg2(WB);
    localparam int unsigned OFF = woff(s);
    assign o_cyc[s] = m_cyc & hit[s];
    assign o_stb[s] = m_stb & hit[s];
    assign o_we[s]  = m_we;
    busdec_wsteer #(.MB(MB), .WB(WB)) u_ws (
      .grow(grp[LW][MB/WB-1:0]), .m_sel(m_sel), .m_wdat(m_wdat),
      .s_sel(o_sel[OFF/8 +: WB]), .s_wdat(o_wdat[OFF +: SLV_W[s]])
    );
  end

  busdec_rmerge #(.MB(MB), .NS(NS), .SLV_W(SLV_W)) u_rm (
    .hit(hit), .grp(grp), .i_rdat(i_rdat), .i_ack(i_ack),
    .m_rdat(m_rdat), .m_ack(m_ack)
  );

  always_comb begin
    p_single_cycle_r1: assert ($onehot0(o_cyc));
    if (!m_stb) begin
      p_strobe_gate_r2: assert (o_stb == '0);
    end
  end
endmodule

// File: tb/busdec_wa_bench.sv
module busdec_wa_bench;
  localparam int CLK_P = 10;
  localparam int NSL = 3;
  localparam int MBY = 4;
  localparam int WID [NSL] = '{8, 16, 32};
  localparam int BAS [NSL] = '{'h0000, 'h0100, 'h1000};
  localparam int SZ  [NSL] = '{256, 256, 4096};
  localparam int BOF [NSL] = '{0, 8, 24};

  logic clk = 0;
  logic rst = 1;
  always #(CLK_P/2) clk = ~clk;

  logic        m_cyc = 0, m_stb = 0, m_we = 0;
  logic [15:0] m_adr = '0;
  logic [3:0]  m_sel = '0;
  logic [31:0] m_wdat = '0;
  logic [31:0] m_rdat;
  logic        m_ack;
  logic [2:0]  o_cyc, o_stb, o_we;
  logic [47:0] o_adr;
  logic [6:0]  o_sel;
  logic [55:0] o_wdat;
  logic [55:0] i_rdat;
  logic [2:0]  i_ack = '0;
  logic [31:0] sd [NSL];

  assign i_rdat = {sd[2][31:0], sd[1][15:0], sd[0][7:0]};

  busdec_wa u_busdec_wa (
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr), .m_sel(m_sel),
    .m_wdat(m_wdat), .m_rdat(m_rdat), .m_ack(m_ack), .o_cyc(o_cyc),
    .o_stb(o_stb), .o_we(o_we), .o_adr(o_adr), .o_sel(o_sel),
    .o_wdat(o_wdat), .i_rdat(i_rdat), .i_ack(i_ack)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s adr=%h act=%h exp=%h", tag, m_adr, act, exp);
    end
  endtask

  // Behavioural reference, evaluated from the port values of this cycle.
  task automatic check_all();
    int a, hits;
    logic [63:0] eack, erd;
    a = int'(m_adr);
    eack = 0;
    erd = 0;
    hits = 0;
    for (int s = 0; s < NSL; s++) begin
      int wb, g;
      logic sel_s;
      sel_s = m_cyc && (a >= BAS[s]) && (a < BAS[s] + SZ[s]);
      wb = WID[s] / 8;
      g  = (a % MBY) / wb;
      chk("R1 cyc", 64'(o_cyc[s]), 64'(sel_s));
      chk("R2 stb", 64'(o_stb[s]), 64'(m_stb && sel_s));
      chk("R2 we", 64'(o_we[s]), 64'(m_we));
      chk("R2 adr", 64'(o_adr[s*16 +: 16]), 64'(a % SZ[s]));
      chk("R4 sel", 64'((o_sel >> (BOF[s]/8)) & ((1 << wb) - 1)),
          64'((m_sel >> (g*wb)) & ((1 << wb) - 1)));
      chk("R5 wdat", (64'(o_wdat) >> BOF[s]) & ((64'd1 << WID[s]) - 1),
          (64'(m_wdat) >> (g*wb*8)) & ((64'd1 << WID[s]) - 1));
      if (sel_s) begin
        hits++;
        eack = 64'(i_ack[s]);
        erd  = ((64'(sd[s]) & ((64'd1 << WID[s]) - 1)) << (g*wb*8)) & 64'hFFFF_FFFF;
      end
    end
    if (hits == 0) begin
      chk("R7 rdat", 64'(m_rdat), 0);
      chk("R7 ack", 64'(m_ack), 0);
    end else begin
      chk("R6 rdat", 64'(m_rdat), erd);
      chk("R3 ack", 64'(m_ack), eack);
    end
  endtask

  task automatic apply(input logic c, input logic st, input logic w, input int a);
    @(posedge clk);
    #1;
    m_cyc = c; m_stb = st; m_we = w; m_adr = 16'(a);
    m_sel = 4'($urandom); m_wdat = $urandom;
    i_ack = 3'($urandom);
    for (int s = 0; s < NSL; s++) sd[s] = $urandom;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    for (int s = 0; s < NSL; s++) sd[s] = '0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    check_all();  // idle state after reset: R7
    // Lane groups of each width (R4, R5, R6)
    for (int k = 0; k < 4; k++) begin
      apply(1, 1, 1, 'h0000 + k);
      apply(1, 1, 0, 'h0100 + k);
      apply(1, 1, 0, 'h1000 + k);
    end
    // Window edges (R1) and unmapped addresses (R7)
    apply(1, 1, 0, 'h00FF);
    apply(1, 1, 0, 'h01FF);
    apply(1, 1, 0, 'h0200);
    apply(1, 1, 0, 'h0FFF);
    apply(1, 1, 0, 'h1FFF);
    apply(1, 1, 1, 'h2000);
    apply(0, 1, 0, 'h0102);  // no cycle: R7
    apply(1, 0, 1, 'h1002);  // cycle without strobe: R2
    for (int n = 0; n < 400; n++) begin
      apply(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 'h2100));
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule